// File: doc/BRIEF.md
# Fractional-Baud UART Frame Transmitter

This block turns one request at a time into an asynchronous serial frame on a single output line, and it makes its own bit timing. The bit period comes from a 20-bit divider that carries 8 fractional bits: the divider equals 256 times the clock frequency over the baud rate. A phase accumulator spreads the fractional part across the bits of a frame, so the bit edges never drift by more than one clock from their ideal positions.

A request carries a kind (data character, idle frame or break frame) and up to 9 data bits. It is accepted through a valid/ready handshake. Word length, parity, stop-bit count and the divider are captured when the request is accepted and stay fixed for that frame. A divider that is too small raises an error output and blocks acceptance.

Top module: `frac_uart_tx`

## Requirements
- R1: A data frame (`req_kind` 00, or the spare code 11) sends one low start bit and then the character least significant bit first. `cfg_wlen` sets the character size: 00 gives 8 bits, 01 gives 9 bits, 10 gives 7 bits and 11 gives 8 bits.
- R2: With `cfg_par_en` high, the top bit of the character is replaced by a parity bit computed over the lower data bits actually sent, so the character length does not change. `cfg_par_odd` 0 makes the count of ones over data and parity even, and 1 makes it odd.
- R3: `cfg_stop` 10 appends two high stop bits. Every other code appends one.
- R4: An idle frame (`req_kind` 01) keeps the line high for as many bit periods as a data frame with the same settings (start, character and stop bits).
- R5: A break frame (`req_kind` 10) drives the line low for a full data-frame length of bit periods and then high for two more bit periods.
- R6: After the accepting clock edge, bit n of the frame (n from 0) is on the line from edge ceil(n*D/256) through edge ceil((n+1)*D/256), where D is the captured divider and edges are counted from the accepting edge as edge 0.
- R7: When `cfg_div` is 0x300 or less, `div_err` is high, `req_ready` is low and no frame starts while that holds.
- R8: During reset and whenever no frame is active, `tx` is high. `req_ready` rises in the cycle right after the last stop bit ends, when the divider is valid.
- R9: Configuration and request inputs that change after acceptance do not alter the frame in progress. A request held valid is accepted again on the first edge at which `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wlen | input | 2 | Character size code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| cfg_stop | input | 2 | Stop-bit count code |
| cfg_div | input | 20 | Bit-period divider, 256 x clock / baud |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 data, 01 idle, 10 break, 11 data |
| req_data | input | 9 | Character, LSB sent first |
| req_ready | output | 1 | Block can accept a request |
| tx | output | 1 | Serial line |
| div_err | output | 1 | Divider value is invalid |

## Verification
The end of one frame and the acceptance of the next meet at the same boundary. The bench holds `req_valid` high across a whole frame, so the final bit tick and a new handshake come in neighbouring cycles. The per-cycle model then judges the single high cycle between frames and the start of the second frame. The bench also changes every configuration input, and makes the divider invalid, in the cycle right after acceptance. The model expects the running frame to go on with the captured settings while `div_err` rises and `req_ready` stays low at its end.

// File: rtl/fut_pkg.sv
package fut_pkg;

   typedef enum logic [1:0] {
      KIND_DATA  = 2'b00,
      KIND_IDLE  = 2'b01,
      KIND_BREAK = 2'b10,
      KIND_SPARE = 2'b11
   } frame_kind_e;

   // character size from the size code; the spare code falls back to 8
   function automatic logic [3:0] char_bits(input logic [1:0] code);
      case (code)
         2'b01:   char_bits = 4'd9;
         2'b10:   char_bits = 4'd7;
         default: char_bits = 4'd8;
      endcase
   endfunction

   // stop bits from the stop code; only one code selects two
   function automatic logic [1:0] stop_count(input logic [1:0] code);
      stop_count = (code == 2'b10) ? 2'd2 : 2'd1;
   endfunction

endpackage

// File: rtl/fut_baud_tick.sv
module fut_baud_tick #(
   parameter int DIV_W  = 20,
   parameter int FRAC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int ACC_W = DIV_W + 1;
   localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

   if (DIV_W <= FRAC_W) begin : g_bad_width
      $error("fut_baud_tick: DIV_W must exceed FRAC_W");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] div_ext;

   assign div_ext = {1'b0, div};
   assign acc_sum = acc + STEP;
   assign tick    = run && (acc_sum >= div_ext);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         acc <= '0;
      end else if (run) begin
         acc <= tick ? (acc_sum - div_ext) : acc_sum;
      end
   end

   // remainder left behind always stays under one bit period (R6)
   p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (acc < div_ext));

   // a valid divider is over three steps, so ticks never come back to back (R6)
   p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/fut_frame_build.sv
module fut_frame_build
   import fut_pkg::*;
#(
   parameter int DATA_W  = 9,
   parameter int FRAME_W = 14,
   parameter int CNT_W   = 4
) (
   input  frame_kind_e         kind,
   input  logic [DATA_W-1:0]   data,
   input  logic [1:0]          wlen_code,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic [1:0]          stop_code,
   output logic [FRAME_W-1:0]  frame_bits,
   output logic [CNT_W-1:0]    frame_len
);
   if (DATA_W != 9) begin : g_bad_data
      $error("fut_frame_build: size codes need DATA_W of 9");
   end
   if (FRAME_W < DATA_W + 5) begin : g_bad_frame
      $error("fut_frame_build: FRAME_W too small for a break frame");
   end
   if ((1 << CNT_W) <= FRAME_W) begin : g_bad_cnt
      $error("fut_frame_build: CNT_W cannot hold FRAME_W");
   end

   logic [3:0]        wbits;
   logic [1:0]        sbits;
   logic [3:0]        data_cnt;
   logic [DATA_W-1:0] slot_mask;
   logic [DATA_W-1:0] word;
   logic              parity;

   assign wbits    = char_bits(wlen_code);
   assign sbits    = stop_count(stop_code);
   assign data_cnt = wbits - {3'b000, par_en};
   assign parity   = (^(data & slot_mask)) ^ par_odd;

   for (genvar i = 0; i < DATA_W; i++) begin : g_slot
      assign slot_mask[i] = (4'(i) < data_cnt);
      assign word[i]      = (par_en && (4'(i) == wbits - 4'd1)) ? parity : data[i];
   end

   always_comb begin
      int w_i;
      int body_i;
      w_i    = int'(wbits);
      body_i = 1 + w_i + int'(sbits);
      frame_bits = '1;
      frame_len  = CNT_W'(body_i);
      case (kind)
         KIND_IDLE: begin
            frame_len = CNT_W'(body_i);
         end
         KIND_BREAK: begin
            for (int j = 0; j < FRAME_W; j++) begin
               if (j < body_i) frame_bits[j] = 1'b0;
            end
            frame_len = CNT_W'(body_i + 2);
         end
         default: begin
            frame_bits[0] = 1'b0;
            for (int j = 1; j < FRAME_W; j++) begin
               if (j <= w_i) frame_bits[j] = word[j-1];
            end
         end
      endcase
   end

endmodule

// File: rtl/fut_serializer.sv
module fut_serializer #(
   parameter int FRAME_W = 14,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic [CNT_W-1:0]   frame_len,
   input  logic               tick,
   output logic               busy,
   output logic               tx
);
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         busy  <= 1'b0;
         tx    <= 1'b1;
      end else if (load) begin
         shreg <= frame_bits;
         left  <= frame_len;
         busy  <= 1'b1;
         tx    <= frame_bits[0];
      end else if (busy && tick) begin
         shreg <= {1'b1, shreg[FRAME_W-1:1]};
         left  <= left - CNT_W'(1);
         if (left == CNT_W'(1)) begin
            busy <= 1'b0;
            tx   <= 1'b1;
         end else begin
            tx   <= shreg[1];
         end
      end
   end

   // line rests high outside a frame (R8)
   p_line_rest_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx);

   // a running frame always has bits still to send (R6)
   p_bits_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (left != '0));

endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx
   import fut_pkg::*;
#(
   parameter int DIV_W   = 20,
   parameter int FRAC_W  = 8,
   parameter int DATA_W  = 9,
   parameter int MIN_DIV = 'h300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic [1:0]        cfg_stop,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ready,
   output logic              tx,
   output logic              div_err
);
   localparam int FRAME_W = DATA_W + 5;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

   if (MIN_DIV < (1 << FRAC_W)) begin : g_bad_min
      $error("frac_uart_tx: MIN_DIV must be at least one whole clock");
   end

   logic               busy;
   logic               accept;
   logic               tick;
   logic [DIV_W-1:0]   div_q;
   logic [FRAME_W-1:0] frame_bits;
   logic [CNT_W-1:0]   frame_len;

   assign div_err   = (cfg_div <= MIN_DIV_V);
   assign req_ready = !busy && !div_err;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '1;
      end else if (accept) begin
         div_q <= cfg_div;
      end
   end

   fut_frame_build #(
      .DATA_W  (DATA_W),
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_build (
      .kind       (frame_kind_e'(req_kind)),
      .data       (req_data),
      .wlen_code  (cfg_wlen),
      .par_en     (cfg_par_en),
      .par_odd    (cfg_par_odd),
      .stop_code  (cfg_stop),
      .frame_bits (frame_bits),
      .frame_len  (frame_len)
   );

   fut_baud_tick #(
      .DIV_W  (DIV_W),
      .FRAC_W (FRAC_W)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (busy),
      .div     (div_q),
      .tick    (tick)
   );

   fut_serializer #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .frame_bits (frame_bits),
      .frame_len  (frame_len),
      .tick       (tick),
      .busy       (busy),
      .tx         (tx)
   );

   // no frame may begin while the divider is out of range (R7)
   p_no_start_bad_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!div_err));

   // every frame except idle opens with a low bit (R1, R5)
   p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && ($past(req_kind) != 2'b01)) |-> !tx);

   // the line is high once the last stop bit is done (R8)
   p_end_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> tx);

endmodule

// File: tb/sim_frac_uart_tx.sv
module sim_frac_uart_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_wlen = 2'b00;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic [1:0] cfg_stop = 2'b00;
   logic [19:0] cfg_div = 20'h360;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic [8:0] req_data = '0;
   logic       req_ready;
   logic       tx;
   logic       div_err;

   always #4 clk = ~clk;

   frac_uart_tx u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_div(cfg_div),
      .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
      .req_ready(req_ready), .tx(tx), .div_err(div_err)
   );

   int    checks = 0;
   int    fails = 0;
   string cur_tag = "R8";
   bit    cmp_en = 1'b0;

   // reference model state
   bit     mbits[0:15];
   int     mlen = 0;
   longint mdiv = 1;
   int     mc = 0;
   bit     mbusy = 1'b0;
   int     acc_cnt = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic void build(input logic [1:0] k, input logic [8:0] d,
                                 input logic [1:0] wl, input logic pe, input logic po,
                                 input logic [1:0] sb);
      int w;
      int s;
      int body;
      int ones;
      int nd;
      w = (wl == 2'b01) ? 9 : (wl == 2'b10) ? 7 : 8;
      s = (sb == 2'b10) ? 2 : 1;
      body = 1 + w + s;
      ones = 0;
      for (int j = 0; j < 16; j++) mbits[j] = 1'b1;
      if (k == 2'b01) begin
         mlen = body;
      end else if (k == 2'b10) begin
         for (int j = 0; j < body; j++) mbits[j] = 1'b0;
         mlen = body + 2;
      end else begin
         mbits[0] = 1'b0;
         nd = pe ? w - 1 : w;
         for (int i = 0; i < nd; i++) begin
            mbits[1+i] = d[i];
            if (d[i]) ones++;
         end
         if (pe) mbits[w] = bit'(ones % 2) ^ po;
         mlen = body;
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mbusy = 1'b0;
      end else if (mbusy) begin
         mc++;
         if ((longint'(mc) * 256) / mdiv >= mlen) mbusy = 1'b0;
      end else if (req_valid && (cfg_div > 20'h300)) begin
         build(req_kind, req_data, cfg_wlen, cfg_par_en, cfg_par_odd, cfg_stop);
         mdiv = longint'(cfg_div);
         mc = 0;
         mbusy = 1'b1;
         acc_cnt++;
      end
   end

   always @(negedge clk) begin
      #1;
      if (cmp_en) begin
         bit exp_tx;
         bit exp_rdy;
         bit exp_err;
         exp_tx  = mbusy ? mbits[int'((longint'(mc) * 256) / mdiv)] : 1'b1;
         exp_err = (cfg_div <= 20'h300);
         exp_rdy = !mbusy && !exp_err;
         chk(tx == exp_tx, cur_tag, "tx", tx, exp_tx);
         chk(req_ready == exp_rdy, cur_tag, "req_ready", req_ready, exp_rdy);
         chk(div_err == exp_err, "R7", "div_err", div_err, exp_err);
      end
   end

   task automatic send(input string tag, input logic [1:0] k, input logic [8:0] d,
                       input logic [1:0] wl, input logic pe, input logic po,
                       input logic [1:0] sb, input logic [19:0] dv, input bit scramble);
      int a0;
      @(negedge clk);
      cur_tag = tag;
      cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = sb; cfg_div = dv;
      req_kind = k; req_data = d; req_valid = 1'b1;
      a0 = acc_cnt;
      while (acc_cnt == a0) @(negedge clk);
      req_valid = 1'b0;
      if (scramble) begin
         // R9: everything changes right after acceptance, divider made invalid
         cfg_wlen = ~wl; cfg_par_en = ~pe; cfg_par_odd = ~po; cfg_stop = ~sb;
         cfg_div = 20'h200; req_kind = ~k; req_data = ~d;
      end
      while (mbusy) @(negedge clk);
      repeat (3) @(negedge clk);
      cfg_div = dv;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int a0;
      repeat (4) @(negedge clk);
      // R8: line high during reset
      chk(tx == 1'b1, "R8", "tx in reset", tx, 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(tx == 1'b1, "R8", "tx after reset", tx, 1);
      chk(req_ready == 1'b1, "R8", "ready after reset", req_ready, 1);
      cmp_en = 1'b1;

      // R1 / R6: sizes, LSB first, fractional bit periods
      send("R1", 2'b00, 9'h0A5, 2'b00, 0, 0, 2'b00, 20'h360, 0);
      send("R1", 2'b00, 9'h1C3, 2'b01, 0, 0, 2'b00, 20'h301, 0);
      send("R1", 2'b00, 9'h05A, 2'b10, 0, 0, 2'b00, 20'h455, 0);
      send("R1", 2'b11, 9'h1F0, 2'b11, 0, 0, 2'b00, 20'h360, 0);
      send("R6", 2'b00, 9'h133, 2'b00, 0, 0, 2'b00, 20'h1234, 0);
      send("R6", 2'b00, 9'h0CC, 2'b01, 0, 0, 2'b00, 20'h3FF, 0);
      // R2: parity replaces top bit, even and odd
      send("R2", 2'b00, 9'h0B7, 2'b00, 1, 0, 2'b00, 20'h360, 0);
      send("R2", 2'b00, 9'h0B7, 2'b00, 1, 1, 2'b00, 20'h360, 0);
      send("R2", 2'b00, 9'h155, 2'b01, 1, 1, 2'b00, 20'h3A0, 0);
      send("R2", 2'b00, 9'h03F, 2'b10, 1, 0, 2'b00, 20'h3A0, 0);
      // R3: stop-bit codes
      send("R3", 2'b00, 9'h081, 2'b00, 0, 0, 2'b10, 20'h360, 0);
      send("R3", 2'b00, 9'h081, 2'b00, 0, 0, 2'b01, 20'h360, 0);
      send("R3", 2'b00, 9'h1FF, 2'b01, 1, 0, 2'b10, 20'h500, 0);
      // R4: idle frame, R5: break frame
      send("R4", 2'b01, 9'h000, 2'b00, 0, 0, 2'b10, 20'h360, 0);
      send("R4", 2'b01, 9'h000, 2'b10, 1, 0, 2'b00, 20'h400, 0);
      send("R5", 2'b10, 9'h1FF, 2'b00, 0, 0, 2'b00, 20'h360, 0);
      send("R5", 2'b10, 9'h1FF, 2'b01, 0, 0, 2'b10, 20'h3C0, 0);

      // R7: boundary divider refused, line stays high, no acceptance
      @(negedge clk);
      cur_tag = "R7";
      cfg_div = 20'h300; req_kind = 2'b00; req_data = 9'h000; req_valid = 1'b1;
      a0 = acc_cnt;
      repeat (20) @(negedge clk);
      #2;
      chk(div_err == 1'b1, "R7", "div_err at 0x300", div_err, 1);
      chk(req_ready == 1'b0, "R7", "ready at 0x300", req_ready, 0);
      chk(tx == 1'b1, "R7", "tx at 0x300", tx, 1);
      chk(acc_cnt == a0, "R7", "frames started", acc_cnt - a0, 0);
      @(negedge clk);
      cfg_div = 20'h000;
      repeat (5) @(negedge clk);
      #2;
      chk(tx == 1'b1 && req_ready == 1'b0, "R7", "tx/ready at zero div", {tx, req_ready}, 2);
      @(negedge clk);
      req_valid = 1'b0;
      cfg_div = 20'h360;

      // R9: inputs scrambled mid-frame, divider made invalid
      send("R9", 2'b00, 9'h0E1, 2'b00, 1, 0, 2'b10, 20'h360, 1);
      send("R9", 2'b10, 9'h000, 2'b10, 0, 0, 2'b00, 20'h3A0, 1);

      // R9 / R8: back-to-back frames with valid held high
      @(negedge clk);
      cur_tag = "R9";
      cfg_wlen = 2'b00; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop = 2'b00;
      cfg_div = 20'h380; req_kind = 2'b00; req_data = 9'h069; req_valid = 1'b1;
      a0 = acc_cnt;
      while (acc_cnt < a0 + 3) @(negedge clk);
      req_valid = 1'b0;
      while (mbusy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(acc_cnt == a0 + 3, "R9", "back-to-back frames", acc_cnt - a0, 3);

      cmp_en = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule